// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a synthesizable model of a pipelined single-port synchronous SRAM with a word made of byte lanes (four lanes of eight bits by default) and a small, parameterized depth. Every control input is registered on the rising clock edge. Each registered cycle is classified by a decoder as a deselect, a new access at an external address, a continuation at the next burst address, or a suspension at the held address. The decoder also decides whether the cycle reads or writes.

Two address strobes start new accesses. The host strobe has priority, needs the primary enable low, and always starts a read. A write at that address is then issued in the following cycle with no strobe. The controller strobe starts a read or a write according to the write controls. Writes are byte-masked. Read data comes out through an output register, and a write is visible to a read in the very next cycle. The three-state output driver is modelled as a data-valid flag: a drive state combined with the asynchronous output-enable input.

Top module: `ssr_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block is deselected and its drive state is cleared, so `rvalid` is 0. After reset, cycles with no strobe leave `rvalid` at 0.
- R2: An access is selected only if, in the cycle that loads an address, `en_a_n`=0, `en_b_n`=0 and `en_c`=1. Any other combination deselects the block: `rvalid` falls one edge after the loading edge, and later cycles with no strobe, including advance cycles, leave it at 0.
- R3: With `strobe_host_n`=0 and `en_a_n`=0 in a selected cycle, `addr` is loaded and a read is performed whatever the write controls say. `rdata` holds the word at the second rising edge after the inputs were presented, with `rvalid`=1.
- R4: While `en_a_n`=1, `strobe_host_n` has no effect. The cycle is decoded as if that strobe were high.
- R5: `strobe_ctl_n`=0 loads `addr` (or deselects, per R2) and performs a write if the write controls request one, otherwise a read. When both strobes are effective, the host strobe wins and the cycle is a read.
- R6: `write_all_n`=0 writes all lanes. Otherwise, `lane_wr_n`=0 writes each lane n whose `lane_sel_n[n]`=0, and lane n is `wdata[8n+7:8n]`. `lane_sel_n` is ignored while `lane_wr_n`=1, and with no lane requested the cycle is a read.
- R7: In an active access with no effective strobe and `advance_n`=0, the address advances: its two low bits count up by one modulo 4 and the upper bits stay the same.
- R8: In an active access with no effective strobe and `advance_n`=1, the address is held. A read cycle there repeats the read of the same word.
- R9: A read issued in the cycle right after a write to the same address returns the newly written lanes.
- R10: After a write, `rvalid` is 0 from the next edge on. A suspend cycle with read controls does not drive it again; only a strobe or an advance cycle starts a new read.
- R11: `rvalid` is the drive state gated by `out_en_n`=0, and it follows `out_en_n` without waiting for a clock. A write cycle clears the drive state whatever `out_en_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | External word address |
| en_a_n | input | 1 | Primary enable, active low; also qualifies the host strobe |
| en_b_n | input | 1 | Second enable, active low |
| en_c | input | 1 | Third enable, active high |
| strobe_host_n | input | 1 | Host address strobe, active low, always reads |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low; high suspends |
| write_all_n | input | 1 | Write every lane, active low |
| lane_wr_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| wdata | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Registered read data |
| rvalid | output | 1 | Read data is being driven |

## Verification
A wrong selection or last-op state shows up as `rvalid` taking the wrong level one edge after the cycle that caused it, and the bench compares that flag on every clock. A wrong burst address shows up as the wrong word in `rdata` exactly two edges after the advancing cycle. A wrong lane mask, or a lost write, appears only when that word is read back, so every write is followed by a readback within a few cycles. The reference model keeps its own memory image and pipeline in plain bench variables, so a divergence is reported in the cycle where it first reaches the ports.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   // Operation handed from the decode stage to the array stage.
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,   // keep output state
      OP_OFF   = 2'd1,   // deselect: stop driving
      OP_READ  = 2'd2,
      OP_WRITE = 2'd3
   } ssr_op_e;
endpackage

// File: rtl/ssr_decode.sv
module ssr_decode import ssr_pkg::*; #(
   parameter int LANES = 4
) (
   input  logic             en_a_n,
   input  logic             en_b_n,
   input  logic             en_c,
   input  logic             strobe_host_n,
   input  logic             strobe_ctl_n,
   input  logic             advance_n,
   input  logic             write_all_n,
   input  logic             lane_wr_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             active_q,
   input  logic             last_wr_q,
   output logic             load,
   output logic             step,
   output logic             active_d,
   output ssr_op_e          op_d,
   output logic [LANES-1:0] mask_d
);
   if (LANES < 1) begin : g_bad_lanes
      $error("ssr_decode: LANES must be at least 1");
   end

   logic             sel;
   logic             host_go;
   logic             ctl_go;
   logic [LANES-1:0] wr_mask;
   logic             wr_req;

   always_comb begin
      sel     = !en_a_n && !en_b_n && en_c;
      host_go = !strobe_host_n && !en_a_n;
      ctl_go  = !strobe_ctl_n;
      if (!write_all_n)    wr_mask = '1;
      else if (!lane_wr_n) wr_mask = ~lane_sel_n;
      else                 wr_mask = '0;
      wr_req  = |wr_mask;

      load     = 1'b0;
      step     = 1'b0;
      active_d = active_q;
      op_d     = OP_HOLD;
      mask_d   = '0;
      if (host_go) begin
         // host strobe: always a read, write controls ignored
         load     = 1'b1;
         active_d = sel;
         op_d     = sel ? OP_READ : OP_OFF;
      end else if (ctl_go) begin
         load     = 1'b1;
         active_d = sel;
         if (!sel) begin
            op_d = OP_OFF;
         end else if (wr_req) begin
            op_d   = OP_WRITE;
            mask_d = wr_mask;
         end else begin
            op_d = OP_READ;
         end
      end else if (active_q) begin
         step = !advance_n;
         if (wr_req) begin
            op_d   = OP_WRITE;
            mask_d = wr_mask;
         end else if (!advance_n || !last_wr_q) begin
            op_d = OP_READ;
         end
      end
   end
endmodule

// File: rtl/ssr_addr_reg.sv
module ssr_addr_reg #(
   parameter int ADDR_W     = 6,
   parameter int BURST_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_q
);
   if (BURST_BITS < 1 || BURST_BITS >= ADDR_W) begin : g_bad_burst
      $error("ssr_addr_reg: BURST_BITS must lie in 1..ADDR_W-1");
   end

   localparam int HI_W = ADDR_W - BURST_BITS;

   logic [BURST_BITS-1:0] low_nxt;

   always_comb low_nxt = addr_q[BURST_BITS-1:0] + BURST_BITS'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= addr_in;
      else if (step) addr_q <= {addr_q[ADDR_W-1:BURST_BITS], low_nxt};
   end

   // R7: advance counts the low bits and keeps the upper bits
   a_r7_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (addr_q[BURST_BITS-1:0] == $past(addr_q[BURST_BITS-1:0]) + BURST_BITS'(1))
                       && (addr_q[ADDR_W-1:BURST_BITS] == $past(addr_q[ADDR_W-1:BURST_BITS])));

   // R8: no load and no advance keeps the address
   a_r8_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(addr_q));

   logic [HI_W-1:0] unused_hi;
   assign unused_hi = addr_q[ADDR_W-1:BURST_BITS];
endmodule

// File: rtl/ssr_array.sv
module ssr_array import ssr_pkg::*; #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ssr_op_e           op_q,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] data_q,
   input  logic [LANES-1:0]  mask_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              drive_q
);
   if (DEPTH > 4096) begin : g_bad_depth
      $error("ssr_array: ADDR_W too large for a model array");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];
      logic [LANE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (op_q == OP_WRITE && mask_q[l])
            store[addr_q] <= data_q[l*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                lane_q <= '0;
         else if (op_q == OP_READ)  lane_q <= store[addr_q];
      end

      assign rdata_q[l*LANE_W +: LANE_W] = lane_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) drive_q <= 1'b0;
      else begin
         case (op_q)
            OP_READ:           drive_q <= 1'b1;
            OP_WRITE, OP_OFF:  drive_q <= 1'b0;
            default:           drive_q <= drive_q;
         endcase
      end
   end

   // R3: a registered read drives the output on the next edge
   a_r3_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_READ) |=> drive_q);

   // R10: a registered write releases the output on the next edge
   a_r10_write_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_WRITE) |=> !drive_q);
endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl import ssr_pkg::*; #(
   parameter int ADDR_W     = 6,
   parameter int LANES      = 4,
   parameter int LANE_W     = 8,
   parameter int BURST_BITS = 2,
   localparam int DATA_W    = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en_a_n,
   input  logic              en_b_n,
   input  logic              en_c,
   input  logic              strobe_host_n,
   input  logic              strobe_ctl_n,
   input  logic              advance_n,
   input  logic              write_all_n,
   input  logic              lane_wr_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic              out_en_n,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("ssr_ctrl: LANE_W must be at least 1");
   end

   logic              load;
   logic              step;
   logic              active_d;
   ssr_op_e           op_d;
   logic [LANES-1:0]  mask_d;
   logic              active_q;
   logic              last_wr_q;
   ssr_op_e           op_q;
   logic [LANES-1:0]  mask_q;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] addr_q;
   logic              drive_q;

   ssr_decode #(.LANES(LANES)) u_decode (
      .en_a_n        (en_a_n),
      .en_b_n        (en_b_n),
      .en_c          (en_c),
      .strobe_host_n (strobe_host_n),
      .strobe_ctl_n  (strobe_ctl_n),
      .advance_n     (advance_n),
      .write_all_n   (write_all_n),
      .lane_wr_n     (lane_wr_n),
      .lane_sel_n    (lane_sel_n),
      .active_q      (active_q),
      .last_wr_q     (last_wr_q),
      .load          (load),
      .step          (step),
      .active_d      (active_d),
      .op_d          (op_d),
      .mask_d        (mask_d)
   );

   ssr_addr_reg #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .addr_in (addr),
      .addr_q  (addr_q)
   );

   // cycle registers: everything sampled on the rising edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         last_wr_q <= 1'b0;
         op_q      <= OP_HOLD;
         mask_q    <= '0;
         data_q    <= '0;
      end else begin
         active_q <= active_d;
         op_q     <= op_d;
         mask_q   <= mask_d;
         if (op_d == OP_WRITE) data_q <= wdata;
         if (op_d == OP_WRITE)     last_wr_q <= 1'b1;
         else if (op_d == OP_READ) last_wr_q <= 1'b0;
      end
   end

   ssr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_q    (op_q),
      .addr_q  (addr_q),
      .data_q  (data_q),
      .mask_q  (mask_q),
      .rdata_q (rdata),
      .drive_q (drive_q)
   );

   assign rvalid = drive_q && !out_en_n;

   // R3: an effective, selected host strobe registers a read
   a_r3_host_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_host_n && !en_a_n && !en_b_n && en_c) |=> (op_q == OP_READ));

   // R2: a controller load with a failing enable deselects
   a_r2_ctl_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_ctl_n && (strobe_host_n || en_a_n) && (en_a_n || en_b_n || !en_c))
         |=> (!active_q && op_q == OP_OFF));

   // R6: a registered write always carries at least one lane
   a_r6_lane_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_WRITE) |-> (mask_q != '0));
endmodule

// File: tb/tb_ssr_ctrl.sv
module tb_ssr_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  addr;
   logic        en_a_n, en_b_n, en_c;
   logic        strobe_host_n, strobe_ctl_n, advance_n;
   logic        write_all_n, lane_wr_n;
   logic [3:0]  lane_sel_n;
   logic [31:0] wdata;
   logic        out_en_n;
   logic [31:0] rdata;
   logic        rvalid;

   always #(CLK_PERIOD/2) clk = ~clk;

   ssr_ctrl dut (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c),
      .strobe_host_n(strobe_host_n), .strobe_ctl_n(strobe_ctl_n),
      .advance_n(advance_n), .write_all_n(write_all_n),
      .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n), .wdata(wdata),
      .out_en_n(out_en_n), .rdata(rdata), .rvalid(rvalid)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 0;
   string cur_req = "R1";

   // reference model state
   logic [31:0] m_mem [64];
   bit          m_active, m_lastwr;
   logic [5:0]  m_addr;
   int          p_op;          // 0 hold, 1 off, 2 read, 3 write
   logic [5:0]  p_addr;
   logic [31:0] p_data;
   logic [3:0]  p_mask;
   bit          e_drive;
   logic [31:0] e_rdata;

   function automatic logic [31:0] fillv(int a);
      return {8'h5A, 8'(a), 8'(~a), 8'(a * 3)};
   endfunction

   task automatic model_step();
      bit sel, host, ctl, wreq;
      logic [3:0] wm;
      int nop;
      if (!rst_n) begin
         m_active = 0; m_lastwr = 0; m_addr = '0;
         p_op = 0; e_drive = 0; e_rdata = '0;
         return;
      end
      if (p_op == 3) begin
         for (int l = 0; l < 4; l++)
            if (p_mask[l]) m_mem[p_addr][8*l +: 8] = p_data[8*l +: 8];
         e_drive = 0;
      end else if (p_op == 2) begin
         e_rdata = m_mem[p_addr];
         e_drive = 1;
      end else if (p_op == 1) begin
         e_drive = 0;
      end
      sel  = !en_a_n && !en_b_n && en_c;
      host = !strobe_host_n && !en_a_n;
      ctl  = !strobe_ctl_n;
      wm   = !write_all_n ? 4'hF : (!lane_wr_n ? ~lane_sel_n : 4'h0);
      wreq = (wm != 0);
      nop  = 0;
      if (host) begin
         m_addr = addr; m_active = sel; nop = sel ? 2 : 1;
      end else if (ctl) begin
         m_addr = addr; m_active = sel;
         nop = !sel ? 1 : (wreq ? 3 : 2);
      end else if (m_active) begin
         if (!advance_n) m_addr[1:0] = m_addr[1:0] + 2'd1;
         if (wreq) nop = 3;
         else if (!advance_n || !m_lastwr) nop = 2;
      end
      if (nop == 2) m_lastwr = 0;
      if (nop == 3) m_lastwr = 1;
      p_op = nop; p_addr = m_addr; p_data = wdata; p_mask = wm;
   endtask

   task automatic compare();
      bit exp_v;
      exp_v = e_drive && !out_en_n;
      n_tests++;
      if (rvalid !== exp_v) begin
         n_fail++;
         $display("FAIL %s: rvalid=%0b expected %0b", cur_req, rvalid, exp_v);
      end else if (exp_v && rdata !== e_rdata) begin
         n_fail++;
         $display("FAIL %s: rdata=%h expected %h", cur_req, rdata, e_rdata);
      end
   endtask

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic idle();
      en_a_n = 0; en_b_n = 0; en_c = 1;
      strobe_host_n = 1; strobe_ctl_n = 1; advance_n = 1;
      write_all_n = 1; lane_wr_n = 1; lane_sel_n = 4'hF; out_en_n = 0;
   endtask

   task automatic ctl_wr(int a, logic [31:0] d);
      idle(); strobe_ctl_n = 0; addr = 6'(a); wdata = d; write_all_n = 0; cyc();
   endtask
   task automatic ctl_rd(int a);
      idle(); strobe_ctl_n = 0; addr = 6'(a); cyc();
   endtask
   task automatic host_rd(int a);
      idle(); strobe_host_n = 0; addr = 6'(a); cyc();
   endtask
   task automatic adv();
      idle(); advance_n = 0; cyc();
   endtask
   task automatic hold();
      idle(); cyc();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      idle(); addr = '0; wdata = '0; rst_n = 0;
      @(negedge clk);
      // R1: reset
      cur_req = "R1";
      repeat (3) cyc();
      chk("R1", {31'd0, rvalid}, 32'd0);
      rst_n = 1;
      hold(); hold();
      chk("R1", {31'd0, rvalid}, 32'd0);

      // R6: fill all words with full writes
      cur_req = "R6";
      for (int a = 0; a < 64; a++) ctl_wr(a, fillv(a));
      hold();

      // R3: host strobe reads despite write controls, two-edge latency
      cur_req = "R3";
      idle(); strobe_host_n = 0; addr = 6'd5; write_all_n = 0; wdata = '0; cyc();
      hold();
      chk("R3", {31'd0, rvalid}, 32'd1);
      chk("R3", rdata, fillv(5));

      // R9: host read, then write in the suspend cycle, then read right after
      cur_req = "R9";
      host_rd(9);
      idle(); write_all_n = 0; wdata = 32'h0BAD_F00D; cyc();
      ctl_rd(9);
      hold();
      chk("R9", rdata, 32'h0BAD_F00D);

      // R5: both strobes -> host wins, read, no write
      cur_req = "R5";
      idle(); strobe_host_n = 0; strobe_ctl_n = 0; addr = 6'd7;
      write_all_n = 0; wdata = '0; cyc();
      hold();
      chk("R5", rdata, fillv(7));
      ctl_rd(7); hold();
      chk("R5", rdata, fillv(7));

      // R6: single lane, two lanes, and lane selects ignored
      cur_req = "R6";
      idle(); strobe_ctl_n = 0; addr = 6'd12; lane_wr_n = 0; lane_sel_n = 4'b1101;
      wdata = 32'hDEAD_BEEF; cyc();
      ctl_rd(12); hold();
      chk("R6", rdata, (fillv(12) & 32'hFFFF_00FF) | 32'h0000_BE00);
      idle(); strobe_ctl_n = 0; addr = 6'd12; lane_wr_n = 1; lane_sel_n = 4'h0;
      wdata = '0; cyc();
      hold();
      chk("R6", rdata, (fillv(12) & 32'hFFFF_00FF) | 32'h0000_BE00);
      idle(); strobe_ctl_n = 0; addr = 6'd13; lane_wr_n = 0; lane_sel_n = 4'b0110;
      wdata = 32'h1122_3344; cyc();
      ctl_rd(13); hold();
      chk("R6", rdata, (fillv(13) & 32'h00FF_FF00) | 32'h1100_0044);

      // R7 / R8: burst from 18 (low bits 10): 18, 19, 16, 17, then hold
      cur_req = "R7";
      ctl_rd(18);
      adv(); chk("R7", rdata, fillv(18));
      adv(); chk("R7", rdata, fillv(19));
      adv(); chk("R7", rdata, fillv(16));
      hold(); chk("R7", rdata, fillv(17));
      cur_req = "R8";
      hold(); chk("R8", rdata, fillv(17));
      hold(); chk("R8", rdata, fillv(17));

      // R10: write releases the output until a strobe or advance
      cur_req = "R10";
      ctl_wr(20, 32'hCAFE_0001);
      hold(); chk("R10", {31'd0, rvalid}, 32'd0);
      hold(); chk("R10", {31'd0, rvalid}, 32'd0);
      adv();  chk("R10", {31'd0, rvalid}, 32'd0);
      hold(); chk("R10", rdata, fillv(21));
      chk("R10", {31'd0, rvalid}, 32'd1);

      // R11: output enable gates rvalid asynchronously
      cur_req = "R11";
      ctl_rd(22);
      idle(); out_en_n = 1; cyc();
      chk("R11", {31'd0, rvalid}, 32'd0);
      out_en_n = 0; #1;
      chk("R11", {31'd0, rvalid}, 32'd1);
      chk("R11", rdata, fillv(22));
      ctl_wr(23, 32'h7777_0000);
      hold(); chk("R11", {31'd0, rvalid}, 32'd0);

      // R2: deselect via third enable, advance has no effect afterwards
      cur_req = "R2";
      ctl_rd(24);
      idle(); strobe_ctl_n = 0; en_c = 0; addr = 6'd25; cyc();
      chk("R2", rdata, fillv(24));
      adv(); chk("R2", {31'd0, rvalid}, 32'd0);
      adv(); chk("R2", {31'd0, rvalid}, 32'd0);
      host_rd(26); hold();
      chk("R2", rdata, fillv(26));
      idle(); strobe_host_n = 0; en_b_n = 1; addr = 6'd27; cyc();
      hold(); chk("R2", {31'd0, rvalid}, 32'd0);

      // R4: host strobe ignored while primary enable is high
      cur_req = "R4";
      ctl_rd(30);
      idle(); strobe_host_n = 0; en_a_n = 1; addr = 6'd40; cyc();
      hold(); chk("R4", rdata, fillv(30));
      hold(); chk("R4", rdata, fillv(30));

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule